// File: doc/BRIEF.md
# Handshake-Terminated Wait-State Controller

This block stretches processor bus cycles that target a slow peripheral run by firmware. The peripheral may need many of its own clocks to answer. When the peripheral's chip select is seen during a bus cycle, the block pulls the processor's active-high ready line low. This holds the processor in the current cycle. The hold ends only when the peripheral reports that it is finished. At the same moment the block captures which register was addressed and whether the access is a read or a write. It hands this to the peripheral as one byte, and raises a request flag.

The peripheral's completion strobe passes through a register stage and then an edge detector. As a result it acts for exactly one clock, however long the peripheral keeps it high. The ready line is then released. It stays released until chip select drops, so one access cannot put the wait back on. The ready line is shared on the processor side. For that reason the block never drives it high. Its only output to that line is a pull-low enable, and an external pull-up restores the high level.

Top module: `bus_wait_stretcher`

## Requirements
- R1: In idle, asserting `cs` makes `rdy_pull` go to 1 in the same cycle, with no clock edge needed. `rdy_pull` stays 1 on every following cycle until the completion takes effect.
- R2: After `done` rises, the hold ends on the second rising clock edge. After that edge `rdy_pull` is 0 and `req` is 0. Until then `rdy_pull` stays 1.
- R3: A `done` level held high gives only one completion. Keeping it high while `cs` is still asserted after the release does not bring back `rdy_pull`.
- R4: On the edge that leaves idle for the wait, `desc` captures `{rw, addr[6:0]}`: bit 7 is the read/write flag (1 = read) and bits 6..0 are address bits 6..0. `req` is set on that same edge. `desc` then holds this value until the next access, even if `addr` or `rw` change.
- R5: After the release, the block stays released with `rdy_pull` = 0 for as long as `cs` stays high. It returns to idle on the first edge where `cs` is low.
- R6: A completion that arrives while idle has no effect: `req` stays 0 and `rdy_pull` stays 0. It also does not end the next access.
- R7: A synchronous reset forces idle and clears `req` and `desc` to 0. While `rst` is 1, `rdy_pull` is 0.
- R8: If `done` is already high when an access starts, that access is not completed. It stays held until `done` falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-2 bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Decoded peripheral chip select, active high |
| addr | input | 16 | Processor address bus |
| rw | input | 1 | Processor read/write flag, 1 = read |
| done | input | 1 | Peripheral completion level |
| rdy_pull | output | 1 | 1 = pull the ready line low; 0 = leave it to the pull-up |
| desc | output | 8 | Latched access descriptor {rw, addr[6:0]} |
| req | output | 1 | Access pending for the peripheral |

## Verification
`rdy_pull` is due in the same cycle as `cs`, so the bench samples it one time step after it drives `cs`. `desc` and `req` are due after the next rising edge. A rise on `done` becomes visible only after the second rising edge, because the register stage and the edge detector each add one. The bench drives its inputs on falling edges and samples between edges, counting exactly those edges before each comparison. It sweeps all 256 descriptor values with wait lengths that vary from access to access.

// File: rtl/bus_wait_stretcher.sv
module bus_wait_stretcher #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rw,
  input  logic                done,
  output logic                rdy_pull,
  output logic [SEL_W:0]      desc,
  output logic                req
);

  localparam int DESC_W = SEL_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RELEASE} state_t;

  state_t state, state_nx;
  logic done_q, done_qq, done_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      done_qq <= 1'b0;
    end else begin
      done_q  <= done;
      done_qq <= done_q;
    end
  end

  assign done_pulse = done_q & ~done_qq;

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:    if (cs) state_nx = S_WAIT;
      S_WAIT:    if (done_pulse) state_nx = S_RELEASE;
      S_RELEASE: if (!cs) state_nx = S_IDLE;
      default:   state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      req   <= 1'b0;
      desc  <= '0;
    end else begin
      state <= state_nx;
      if (state == S_IDLE && cs) begin
        req  <= 1'b1;
        desc <= DESC_W'({rw, addr[SEL_W-1:0]});
      end else if (state == S_WAIT && done_pulse) begin
        req <= 1'b0;
      end
    end
  end

  assign rdy_pull = !rst && ((state == S_IDLE && cs) || state == S_WAIT);

  a_r1_hold_starts: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && cs) |=> (rdy_pull && req));

  a_r2_release: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && done_pulse) |=> (!rdy_pull && !req));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  a_r4_desc_stable: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) |=> $stable(desc));

  a_r5_stay_released: assert property (@(posedge clk) disable iff (rst)
    (state == S_RELEASE && cs) |=> (state == S_RELEASE && !rdy_pull));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !cs) |=> (state == S_IDLE && !req));

  a_r7_reset: assert property (@(posedge clk)
    rst |=> (state == S_IDLE && !req));

  a_r8_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && !done_pulse) |=> (state == S_WAIT && rdy_pull));

endmodule

// File: tb/bus_wait_stretcher_tb.sv
module bus_wait_stretcher_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0;
  logic [15:0] addr = '0;
  logic rw = 1'b0;
  logic done = 1'b0;
  logic rdy_pull, req;
  logic [7:0] desc;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bus_wait_stretcher dut_i (
    .clk(clk), .rst(rst), .cs(cs), .addr(addr), .rw(rw),
    .done(done), .rdy_pull(rdy_pull), .desc(desc), .req(req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  task automatic access(input logic [6:0] a, input logic r, input int wait_n, input bit keep_done);
    logic [7:0] exp;
    logic [15:0] full;
    full = {9'(a * 3 + 5), a};
    exp = {r, a};
    @(negedge clk);
    cs = 1'b1; addr = full; rw = r;
    #1;
    chk("R1 pull same cycle", rdy_pull, 1);
    step();
    chk("R4 desc capture", desc, exp);
    chk("R4 req set", req, 1);
    chk("R1 pull held", rdy_pull, 1);
    addr = ~full; rw = ~r;
    for (int k = 0; k < wait_n; k++) begin
      step();
      chk("R1 pull during wait", rdy_pull, 1);
    end
    done = 1'b1;
    step();
    chk("R2 pull before second edge", rdy_pull, 1);
    step();
    chk("R2 pull released", rdy_pull, 0);
    chk("R2 req cleared", req, 0);
    chk("R4 desc stable", desc, exp);
    step();
    chk("R3 no re-arm", rdy_pull, 0);
    chk("R5 released while cs", rdy_pull, 0);
    cs = 1'b0;
    if (!keep_done) done = 1'b0;
    step();
    chk("R5 idle after cs low", rdy_pull, 0);
    chk("R4 desc kept", desc, exp);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cs = 1'b1;
    step();
    chk("R7 pull off in reset", rdy_pull, 0);
    step();
    chk("R7 req reset", req, 0);
    chk("R7 desc reset", desc, 0);
    cs = 1'b0;
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < 256; i++)
      access(7'(i), i[7], i % 5, 1'b0);

    // R6: completion in idle ignored
    @(negedge clk); done = 1'b1;
    step();
    chk("R6 req idle", req, 0);
    chk("R6 pull idle", rdy_pull, 0);
    @(negedge clk); done = 1'b0; cs = 1'b1; addr = 16'h0042; rw = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R6 stale pulse not consumed", rdy_pull, 1);
    end
    @(negedge clk); done = 1'b1;
    step(); step();
    chk("R6 later release", rdy_pull, 0);
    @(negedge clk); cs = 1'b0;

    // R8: done still high when the next access starts
    @(negedge clk); cs = 1'b1; addr = 16'h0011; rw = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R8 stale done holds", rdy_pull, 1);
    end
    chk("R8 req pending", req, 1);
    @(negedge clk); done = 1'b0;
    @(negedge clk); done = 1'b1;
    step();
    chk("R8 pull before second edge", rdy_pull, 1);
    step();
    chk("R8 fresh done releases", rdy_pull, 0);
    chk("R8 desc", desc, 8'h91);
    @(negedge clk); cs = 1'b0; done = 1'b0;

    // R7: reset in the middle of a wait
    @(negedge clk); cs = 1'b1; addr = 16'h007f; rw = 1'b1;
    step(); step();
    rst = 1'b1;
    #1;
    chk("R7 pull off when rst", rdy_pull, 0);
    step();
    chk("R7 req cleared", req, 0);
    chk("R7 desc cleared", desc, 0);
    cs = 1'b0;
    @(negedge clk); rst = 1'b0;
    step();
    chk("R7 idle after reset", rdy_pull, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule